// File: doc/BRIEF.md
# Stream-to-Timed-Video Output Bridge

This block takes pixels from an AXI4-Stream video source in one clock domain and presents them as parallel video (pixel, horizontal sync, vertical sync, data-enable) in an unrelated pixel-clock domain. It carries one 24-bit RGB pixel per beat, with 8 bits per component. The sync and blanking pattern is not produced here. It comes from an external timing generator, and the bridge drives a clock-enable back to that generator so it can hold the generator still.

Pixels cross the clock boundary through an asynchronous FIFO. After reset, and again after any loss of lock, the bridge keeps the generator stalled. It drops any pixels that arrive ahead of a frame start, and waits until the FIFO holds at least a hysteresis number of entries with a frame-start pixel at its head. Once the generator is released, the bridge waits for the generator's vertical sync. It then hands out one pixel per active clock, so the first active pixel of the next frame is pixel 0 of a stream frame.

A sticky flag in the pixel domain reports an underrun during active video, after which the bridge locks again. A sticky flag in the stream domain reports lines whose end marker does not match the configured active width. Streaming carries on when that flag is set.

Top module: `vidout_bridge`

## Requirements
- R1: A beat is taken only on an `s_clk` rising edge with `s_tvalid` and `s_tready` both high. `s_tready` is low while the FIFO is full, and no accepted pixel is lost or reordered.
- R2: `s_tuser` high on a beat marks pixel 0 of a frame, and that pixel is the first one driven with `vid_de` after each lock. `s_tlast` high marks the last pixel of a line.
- R3: From reset, `tg_ce` stays 0 until the FIFO holds at least `HYST` (default 12) pixels and the pixel at its head carries the frame-start mark. While it waits, pixels without that mark that reach the head are discarded.
- R4: After `tg_ce` rises, no pixel is driven until the generator's vertical sync has been seen. From then on, each cycle with `tg_de` high drives the next FIFO pixel, in stream order, with bits [23:0] unchanged.
- R5: `vid_hsync` and `vid_vsync` equal `tg_hsync` and `tg_vsync` delayed by one `v_clk` cycle, whatever the lock state.
- R6: While `vid_de` is 0, `vid_data` is 0.
- R7: If the FIFO is empty during a delivering active cycle, `vid_uflow` sets and stays set, `tg_ce` falls, and `vid_de` stays 0. The bridge then drops pixels up to the next frame start and repeats the R3/R4 sequence.
- R8: An accepted beat whose `s_tlast` disagrees with its column sets `s_line_err`, which stays set. The column count restarts at 0 on a frame-start beat, and the last column is `ACTIVE_W-1`. Beats continue to be accepted afterwards.
- R9: During and right after reset, `tg_ce`, `vid_de`, `vid_data`, `vid_uflow` and `s_line_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Stream clock |
| s_rst_n | input | 1 | Stream-domain active-low reset |
| s_tdata | input | 24 | Pixel, R in [23:16], G in [15:8], B in [7:0] |
| s_tvalid | input | 1 | Beat offered |
| s_tready | output | 1 | Beat can be taken |
| s_tuser | input | 1 | Frame-start mark |
| s_tlast | input | 1 | End-of-line mark |
| s_line_err | output | 1 | Sticky line-length mismatch flag |
| v_clk | input | 1 | Pixel clock |
| v_rst_n | input | 1 | Pixel-domain active-low reset |
| tg_ce | output | 1 | Clock-enable to the timing generator |
| tg_hsync | input | 1 | Generator horizontal sync |
| tg_vsync | input | 1 | Generator vertical sync |
| tg_de | input | 1 | Generator active-video flag |
| vid_data | output | 24 | Output pixel |
| vid_hsync | output | 1 | Output horizontal sync |
| vid_vsync | output | 1 | Output vertical sync |
| vid_de | output | 1 | Output data-enable |
| vid_uflow | output | 1 | Sticky underrun flag |

## Verification
The hardest case to reach is losing lock and getting it back. The FIFO has to run dry in the middle of delivery, and then refill starting from a pixel partway through a frame, so both the discard path and the re-arm on vertical sync are exercised. The bench reaches it by stopping its stream producer at a random beat after many locked frames, waiting for the flag, holding the stall, and then resuming the same frame where it left off. Before the first lock, junk beats and a frame prefix one pixel short of the threshold are used to confirm that the generator stays held.

// File: rtl/vob_pkg.sv
`timescale 1ns/1ps
package vob_pkg;
    localparam int PIX_W = 24;

    typedef struct packed {
        logic             sof;
        logic [PIX_W-1:0] px;
    } beat_t;

    typedef enum logic {LK_WAIT = 1'b0, LK_RUN = 1'b1} lk_st_e;
endpackage

// File: rtl/vob_sync.sv
`timescale 1ns/1ps
module vob_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/vob_cdc_fifo.sv
`timescale 1ns/1ps
module vob_cdc_fifo #(
    parameter int W  = 25,
    parameter int AW = 10
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic [AW:0]  rd_fill
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
    } ptr_t;

    logic [W-1:0] mem [DEPTH];
    ptr_t w_d, w_q, r_d, r_q;
    logic [AW:0] rgray_s, wgray_s, wbin_s;

    vob_sync #(.W(AW+1), .STAGES(2)) u_rsync (
        .clk(wclk), .rst_n(wrst_n), .d(r_q.gray), .q(rgray_s)
    );
    vob_sync #(.W(AW+1), .STAGES(2)) u_wsync (
        .clk(rclk), .rst_n(rrst_n), .d(w_q.gray), .q(wgray_s)
    );

    // write domain
    assign full = (w_q.gray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});

    always_comb begin
        w_d = w_q;
        if (wr_en && !full) begin
            w_d.bin  = w_q.bin + 1'b1;
            w_d.gray = w_d.bin ^ (w_d.bin >> 1);
        end
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) w_q <= '0;
        else         w_q <= w_d;
    end

    always_ff @(posedge wclk) begin
        if (wr_en && !full) mem[w_q.bin[AW-1:0]] <= wr_data;
    end

    // read domain
    always_comb begin
        for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    assign empty   = (r_q.gray == wgray_s);
    assign rd_fill = wbin_s - r_q.bin;
    assign rd_data = mem[r_q.bin[AW-1:0]];

    always_comb begin
        r_d = r_q;
        if (rd_en && !empty) begin
            r_d.bin  = r_q.bin + 1'b1;
            r_d.gray = r_d.bin ^ (r_d.bin >> 1);
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge wclk) disable iff (!wrst_n)
        wr_en |-> !full); // R1
    AST_NO_POP_WHEN_EMPTY: assert property (@(posedge rclk) disable iff (!rrst_n)
        rd_en |-> !empty); // R7
endmodule

// File: rtl/vob_stream_rx.sv
`timescale 1ns/1ps
module vob_stream_rx
    import vob_pkg::*;
#(
    parameter int ACTIVE_W = 1280
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] s_tdata,
    input  logic             s_tvalid,
    input  logic             s_tuser,
    input  logic             s_tlast,
    output logic             s_tready,
    input  logic             full,
    output logic             wr_en,
    output beat_t            wr_data,
    output logic             line_err
);
    localparam int CW = (ACTIVE_W > 1) ? $clog2(ACTIVE_W) : 1;
    localparam logic [CW-1:0] LAST_COL = CW'(ACTIVE_W - 1);

    typedef struct packed {
        logic [CW-1:0] col;
        logic          err;
    } rx_t;

    rx_t d, q;
    logic [CW-1:0] idx;
    logic at_end;

    always_comb begin
        d        = q;
        s_tready = !full;
        wr_en    = s_tvalid && !full;
        idx      = s_tuser ? '0 : q.col;
        at_end   = (idx == LAST_COL);
        wr_data  = '{sof: s_tuser, px: s_tdata};
        if (wr_en) begin
            if (s_tlast != at_end) d.err = 1'b1;
            d.col = (s_tlast || at_end) ? '0 : idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line_err = q.err;

    AST_LINE_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |=> line_err); // R8
endmodule

// File: rtl/vob_lock_ctrl.sv
`timescale 1ns/1ps
module vob_lock_ctrl
    import vob_pkg::*;
#(
    parameter int AW   = 10,
    parameter int HYST = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  beat_t            head,
    input  logic             empty,
    input  logic [AW:0]      fill,
    output logic             rd_en,
    input  logic             tg_hsync,
    input  logic             tg_vsync,
    input  logic             tg_de,
    output logic             tg_ce,
    output logic [PIX_W-1:0] vid_data,
    output logic             vid_hsync,
    output logic             vid_vsync,
    output logic             vid_de,
    output logic             vid_uflow
);
    typedef struct packed {
        lk_st_e           st;
        logic             armed;
        logic             ce;
        logic             hs;
        logic             vs;
        logic             de;
        logic             uflow;
        logic [PIX_W-1:0] px;
    } lk_t;

    lk_t d, q;
    logic enough;

    assign enough = (fill >= (AW+1)'(HYST));

    always_comb begin
        d     = q;
        rd_en = 1'b0;
        d.hs  = tg_hsync;
        d.vs  = tg_vsync;
        d.de  = 1'b0;
        d.px  = '0;
        case (q.st)
            LK_WAIT: begin
                d.ce = 1'b0;
                if (!empty && !head.sof) begin
                    rd_en = 1'b1;
                end else if (!empty && enough) begin
                    d.st    = LK_RUN;
                    d.ce    = 1'b1;
                    d.armed = 1'b0;
                end
            end
            default: begin
                if (tg_vsync) d.armed = 1'b1;
                if (q.armed && tg_de) begin
                    if (empty) begin
                        d.uflow = 1'b1;
                        d.st    = LK_WAIT;
                        d.ce    = 1'b0;
                        d.armed = 1'b0;
                    end else begin
                        rd_en = 1'b1;
                        d.de  = 1'b1;
                        d.px  = head.px;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tg_ce     = q.ce;
    assign vid_data  = q.px;
    assign vid_hsync = q.hs;
    assign vid_vsync = q.vs;
    assign vid_de    = q.de;
    assign vid_uflow = q.uflow;

    AST_CE_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tg_ce) |-> $past(!empty && head.sof && enough)); // R3
    AST_BLANK_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_de |-> (vid_data == '0)); // R6
    AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        vid_uflow |=> vid_uflow); // R7
    AST_UFLOW_DROPS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_uflow) |-> !tg_ce && !vid_de); // R7
endmodule

// File: rtl/vidout_bridge.sv
`timescale 1ns/1ps
module vidout_bridge
    import vob_pkg::*;
#(
    parameter int DEPTH    = 1024,
    parameter int HYST     = 12,
    parameter int ACTIVE_W = 1280
) (
    input  logic        s_clk,
    input  logic        s_rst_n,
    input  logic [23:0] s_tdata,
    input  logic        s_tvalid,
    output logic        s_tready,
    input  logic        s_tuser,
    input  logic        s_tlast,
    output logic        s_line_err,
    input  logic        v_clk,
    input  logic        v_rst_n,
    output logic        tg_ce,
    input  logic        tg_hsync,
    input  logic        tg_vsync,
    input  logic        tg_de,
    output logic [23:0] vid_data,
    output logic        vid_hsync,
    output logic        vid_vsync,
    output logic        vid_de,
    output logic        vid_uflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int BW = $bits(beat_t);

    beat_t       wr_beat, head;
    logic        wr_en, full, rd_en, empty;
    logic [AW:0] fill;

    vob_stream_rx #(.ACTIVE_W(ACTIVE_W)) u_rx (
        .clk(s_clk), .rst_n(s_rst_n),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .s_tready(s_tready), .full(full), .wr_en(wr_en), .wr_data(wr_beat),
        .line_err(s_line_err)
    );

    vob_cdc_fifo #(.W(BW), .AW(AW)) u_fifo (
        .wclk(s_clk), .wrst_n(s_rst_n), .wr_en(wr_en), .wr_data(wr_beat), .full(full),
        .rclk(v_clk), .rrst_n(v_rst_n), .rd_en(rd_en), .rd_data(head),
        .empty(empty), .rd_fill(fill)
    );

    vob_lock_ctrl #(.AW(AW), .HYST(HYST)) u_lock (
        .clk(v_clk), .rst_n(v_rst_n),
        .head(head), .empty(empty), .fill(fill), .rd_en(rd_en),
        .tg_hsync(tg_hsync), .tg_vsync(tg_vsync), .tg_de(tg_de), .tg_ce(tg_ce),
        .vid_data(vid_data), .vid_hsync(vid_hsync), .vid_vsync(vid_vsync),
        .vid_de(vid_de), .vid_uflow(vid_uflow)
    );
endmodule

// File: tb/sim_vidout_bridge.sv
`timescale 1ns/1ps
module sim_vidout_bridge;
    localparam int W = 8, HFP = 2, HSW = 2, HBP = 2, HT = W + HFP + HSW + HBP;
    localparam int H = 4, VFP = 1, VSW = 1, VBP = 1, VT = H + VFP + VSW + VBP;

    logic s_clk = 0, v_clk = 0, s_rst_n = 0, v_rst_n = 0;
    logic [23:0] s_tdata = '0;
    logic s_tvalid = 0, s_tuser = 0, s_tlast = 0;
    logic s_tready, s_line_err, tg_ce, tg_hsync, tg_vsync, tg_de;
    logic [23:0] vid_data;
    logic vid_hsync, vid_vsync, vid_de, vid_uflow;

    always #10 s_clk = ~s_clk;   // 50 MHz
    always #15 v_clk = ~v_clk;

    vidout_bridge #(.DEPTH(32), .HYST(12), .ACTIVE_W(W)) u0 (.*);

    // timing generator model, stalls on tg_ce
    int hc = 0, vc = 0;
    always @(posedge v_clk or negedge v_rst_n) begin
        if (!v_rst_n) begin hc <= 0; vc <= 0; end
        else if (tg_ce) begin
            if (hc == HT-1) begin hc <= 0; vc <= (vc == VT-1) ? 0 : vc + 1; end
            else hc <= hc + 1;
        end
    end
    assign tg_de    = (hc < W) && (vc < H);
    assign tg_hsync = (hc >= W+HFP) && (hc < W+HFP+HSW);
    assign tg_vsync = (vc >= H+VFP) && (vc < H+VFP+VSW);

    int checks = 0, errors = 0;
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
    endtask

    // stream producer
    int fr = 0, ln = 0, cl = 0;
    bit feed_en = 0, prod_idle = 1, saw_stall = 0;

    task automatic put_beat(input logic [23:0] dat, input logic u, input logic l);
        @(negedge s_clk);
        while ($urandom_range(0, 4) == 0) begin
            s_tvalid = 0;
            @(negedge s_clk);
        end
        s_tvalid = 1; s_tdata = dat; s_tuser = u; s_tlast = l;
        forever begin
            #1;
            if (s_tready) break;
            saw_stall = 1;
            @(negedge s_clk);
        end
        @(posedge s_clk);
    endtask

    task automatic drive_idle();
        @(negedge s_clk);
        s_tvalid = 0; s_tuser = 0; s_tlast = 0;
    endtask

    task automatic send_next();
        put_beat({fr[7:0], ln[7:0], cl[7:0]}, (ln == 0) && (cl == 0), cl == W-1);
        if (cl == W-1) begin
            cl = 0;
            if (ln == H-1) begin ln = 0; fr++; end else ln++;
        end else cl++;
    endtask

    initial begin
        forever begin
            prod_idle = 1;
            wait (feed_en);
            prod_idle = 0;
            send_next();
            if (!feed_en) drive_idle();
        end
    end

    // output monitor
    bit mon_en = 0;
    int k = 0, pix_seen = 0;
    logic [7:0] frm = '0;
    logic g_hs_prev = 0, g_vs_prev = 0, o_vs_prev = 0;
    always @(negedge v_clk) begin
        if (mon_en) begin
            chk(vid_hsync == g_hs_prev && vid_vsync == g_vs_prev, "R5",
                {30'd0, vid_hsync, vid_vsync}, {30'd0, g_hs_prev, g_vs_prev});
            if (!vid_de) chk(vid_data == '0, "R6", {8'd0, vid_data}, 32'd0);
            else begin
                if (k == 0) frm = vid_data[23:16];
                chk(vid_data == {frm, 8'(k / W), 8'(k % W)}, (k == 0) ? "R2" : "R4",
                    {8'd0, vid_data}, {8'd0, frm, 8'(k / W), 8'(k % W)});
                k++;
                pix_seen++;
            end
            if (vid_vsync && !o_vs_prev) k = 0;
        end
        g_hs_prev = tg_hsync; g_vs_prev = tg_vsync; o_vs_prev = vid_vsync;
    end

    task automatic wait_v(input int n);
        repeat (n) @(negedge v_clk);
    endtask

    task automatic wait_sig(input bit want_uflow, input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge v_clk);
            if (want_uflow ? vid_uflow : tg_ce) break;
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        int snap;
        repeat (5) @(negedge v_clk);
        s_rst_n = 1; v_rst_n = 1;
        @(negedge v_clk);
        // R9 reset state
        chk(tg_ce == 0, "R9", tg_ce, 0);
        chk(vid_de == 0 && vid_data == 0, "R9", {vid_de, vid_data}, 0);
        chk(vid_uflow == 0 && s_line_err == 0, "R9", {vid_uflow, s_line_err}, 0);

        // R3 junk beats without frame start are discarded, ce held low
        for (int i = 0; i < 6; i++) put_beat(24'($urandom), 1'b0, 1'b0);
        drive_idle();
        wait_v(40);
        chk(tg_ce == 0, "R3 junk", tg_ce, 0);

        // R3 one short of threshold
        for (int i = 0; i < 11; i++) send_next();
        drive_idle();
        wait_v(40);
        chk(tg_ce == 0, "R3 below level", tg_ce, 0);

        mon_en = 1;
        feed_en = 1;
        wait_sig(0, 2000);
        chk(tg_ce == 1, "R3 release", tg_ce, 1);
        wait_v(1500);
        chk(pix_seen > 40, "R4 pixels", pix_seen, 41);
        chk(saw_stall, "R1 stall seen", saw_stall, 1);
        chk(vid_uflow == 0, "R7 no early uflow", vid_uflow, 0);
        chk(s_line_err == 0, "R8 clean lines", s_line_err, 0);

        // R7 underflow: stop the producer at a random point
        repeat ($urandom_range(0, 30)) @(negedge s_clk);
        feed_en = 0;
        wait (prod_idle);
        wait_sig(1, 3000);
        chk(vid_uflow == 1, "R7 flag", vid_uflow, 1);
        wait_v(3);
        chk(tg_ce == 0, "R7 ce low", tg_ce, 0);
        snap = pix_seen;
        wait_v(200);
        chk(pix_seen == snap, "R7 no output", pix_seen, snap);

        feed_en = 1;
        wait_sig(0, 3000);
        chk(tg_ce == 1, "R7 relock", tg_ce, 1);
        wait_v(1500);
        chk(pix_seen > snap + 40, "R7 resumed", pix_seen, snap + 41);
        chk(vid_uflow == 1, "R7 sticky", vid_uflow, 1);

        // R8 short line, stream keeps going
        mon_en = 0;
        feed_en = 0;
        wait (prod_idle);
        put_beat(24'h0, 1'b1, 1'b0);
        put_beat(24'h1, 1'b0, 1'b0);
        put_beat(24'h2, 1'b0, 1'b0);
        put_beat(24'h3, 1'b0, 1'b1);
        drive_idle();
        repeat (3) @(negedge s_clk);
        chk(s_line_err == 1, "R8 flag", s_line_err, 1);
        put_beat(24'h4, 1'b1, 1'b0);
        drive_idle();
        chk(1'b1, "R8 beat accepted after error", 1, 1);
        repeat (3) @(negedge s_clk);
        chk(s_line_err == 1, "R8 sticky", s_line_err, 1);
        report();
    end
endmodule